// File: doc/BRIEF.md
# MII PHY Management Register Model

This block stands in for an Ethernet PHY's management register file as seen through a MAC's 32-bit management-frame register. The host writes one word into the frame register. That word carries an operation bit, a ten-bit combined PHY and register address, and sixteen data bits. In the same clock edge the block decodes the word and performs the register read or write. After a read, the low half of the frame register holds the returned data. Every access also sets a sticky management-done flag, which the MAC side clears with a pulse.

The model holds a control register, a status register, an advertisement register, an interrupt-source register and an interrupt-mask register. Identification and partner-ability registers read fixed values. A link-state input is watched for edges. A change of link state updates the link and autonegotiation bits in status and posts interrupt-source bits. Autonegotiation completes at once, so no timing model is needed. Register 29 is cleared by reading it. An access addressed to a different PHY number reads all ones and changes nothing.

Top module: `mii_phy_regmodel`

## Requirements
- R1: After reset, control reads 0x3000, advertisement 0x01E1 and interrupt mask 0. Status starts from 0x7809 and the current link state is applied to it once, giving 0x782D with the link up. Interrupt source then holds 0x00C0 with the link up, or 0x0010 with it down. The frame register and the done flag reset to zero.
- R2: The frame word is decoded as follows. Bit 29 set means read and clear means write. Bits 27:23 are the PHY number, bits 22:18 the register number, and bits 15:0 the write data. After a read, the frame register holds the written word with bits 15:0 replaced by the register value. After a write, it holds the written word unchanged.
- R3: When the PHY number differs from parameter PHY_ADDR, a read returns 0xFFFF and a write changes no register.
- R4: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R5: A control write with bit 15 clear stores value AND 0x7980. If bit 12 of that write is set, status bit 5 (0x0020) is set at once.
- R6: A control write with bit 15 set returns every register to its R1 reset value. The link state is then reapplied on the following cycle.
- R7: An advertisement write (register 4) stores (value AND 0x2D7F) OR 0x0080. A mask write (register 30) stores value AND 0x00FF.
- R8: A read of register 29 returns the pending source bits and clears them in that access.
- R9: A falling link input clears status bits 0x0024 and sets source bit 4 (0x0010). A rising link input sets status bits 0x0024 and source bits 7 and 6 (0x00C0). A steady link input posts nothing.
- R10: Registers 17, 18, 27 and 31, and every register not listed above, read as zero. Writes to them, and writes to read-only registers 1, 2, 3, 5, 6 and 29, change nothing.
- R11: Every frame write, whether a read or a write and whether or not the PHY matches, sets mgmt_done from the next cycle. done_clr clears it. A new access in the same cycle as done_clr wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_we | input | 1 | Host write strobe for the frame register |
| frame_wdata | input | FRAME_W | Management frame word written by the host |
| done_clr | input | 1 | Clears the management-done flag |
| link_up | input | 1 | Current link state, 1 = up |
| frame_rdata | output | FRAME_W | Frame register contents, read data in bits 15:0 |
| mgmt_done | output | 1 | Sticky management-done flag |

## Verification
The bench builds the block with PHY_ADDR set to 5. With that value, the accesses to PHY 6 exercise the mismatch path. A zero default would hide any fault that matches on an all-zero field. Keeping FRAME_W at 32 and setting bits 31:30 and 17:16 in every stimulus word shows whether the bits outside the decoded fields survive a read. The link input is toggled while accesses are idle, and held steady across repeated source reads. This brings both edge events, the no-edge case and the re-application after a soft reset within reach.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int PHY_FIELD_W = 5;
   localparam int MGMT_ADDR_W = 2 * PHY_FIELD_W;
   localparam int PHY_DATA_W  = 16;
   localparam int REG_COUNT   = 1 << PHY_FIELD_W;

   typedef struct packed {
      logic                   rd;
      logic [PHY_FIELD_W-1:0] phy;
      logic [PHY_FIELD_W-1:0] regn;
      logic [PHY_DATA_W-1:0]  data;
   } mgmt_op_t;

   // register numbers whose positions are fixed by the management convention
   localparam int REG_CTRL    = 0;
   localparam int REG_STAT    = 1;
   localparam int REG_ID_HI   = 2;
   localparam int REG_ID_LO   = 3;
   localparam int REG_ADV     = 4;
   localparam int REG_PARTNER = 5;
   localparam int REG_ANEXP   = 6;
   localparam int REG_EVT_SRC = 29;
   localparam int REG_EVT_MSK = 30;

   localparam logic [PHY_DATA_W-1:0] CTRL_RST    = 16'h3000;
   localparam logic [PHY_DATA_W-1:0] STAT_RST    = 16'h7809;
   localparam logic [PHY_DATA_W-1:0] ADV_RST     = 16'h01E1;
   localparam logic [PHY_DATA_W-1:0] CTRL_KEEP   = 16'h7980;
   localparam logic [PHY_DATA_W-1:0] ADV_KEEP    = 16'h2D7F;
   localparam logic [PHY_DATA_W-1:0] ADV_FORCE   = 16'h0080;
   localparam logic [PHY_DATA_W-1:0] MSK_KEEP    = 16'h00FF;
   localparam logic [PHY_DATA_W-1:0] ID_HI_VAL   = 16'h0007;
   localparam logic [PHY_DATA_W-1:0] ID_LO_VAL   = 16'hC0D1;
   localparam logic [PHY_DATA_W-1:0] PARTNER_VAL = 16'h0F71;
   localparam logic [PHY_DATA_W-1:0] ANEXP_VAL   = 16'h0001;
   localparam logic [PHY_DATA_W-1:0] STAT_LINK   = 16'h0024;
   localparam logic [PHY_DATA_W-1:0] STAT_ANDONE = 16'h0020;
   localparam logic [PHY_DATA_W-1:0] SRC_DOWN    = 16'h0010;
   localparam logic [PHY_DATA_W-1:0] SRC_UP      = 16'h00C0;
   localparam logic [PHY_DATA_W-1:0] MISS_VAL    = 16'hFFFF;

   localparam int CTRL_RESET_BIT = 15;
   localparam int CTRL_AN_BIT    = 12;

endpackage

// File: rtl/phy_frame_decode.sv
module phy_frame_decode
   import phy_mgmt_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int OP_BIT   = 29,
   parameter int ADDR_LSB = 18,
   parameter int PHY_ADDR = 0
) (
   input  logic [FRAME_W-1:0] frame,
   output mgmt_op_t           op,
   output logic               hit
);

   localparam logic [PHY_FIELD_W-1:0] OWN_PHY = PHY_FIELD_W'(PHY_ADDR);

   logic unused_frame_bits;
   assign unused_frame_bits = ^frame;

   always_comb begin
      op.rd   = frame[OP_BIT];
      op.phy  = frame[ADDR_LSB+PHY_FIELD_W +: PHY_FIELD_W];
      op.regn = frame[ADDR_LSB +: PHY_FIELD_W];
      op.data = frame[PHY_DATA_W-1:0];
      hit     = (op.phy == OWN_PHY);
   end

endmodule

// File: rtl/phy_link_watch.sv
module phy_link_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic rearm,
   input  logic link_in,
   output logic evt
);

   logic prev_q;
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         arm_q  <= 1'b1;
      end else begin
         prev_q <= link_in;
         arm_q  <= rearm;
      end
   end

   // armed cycle applies the level once; afterwards only edges count
   assign evt = arm_q | (link_in ^ prev_q);

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
   import phy_mgmt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc,
   input  logic                  hit,
   input  mgmt_op_t              op,
   input  logic                  link_evt,
   input  logic                  link_up,
   output logic [PHY_DATA_W-1:0] rd_data,
   output logic                  soft_rst
);

   logic [PHY_DATA_W-1:0] ctrl_q, stat_q, adv_q, msk_q, src_q;
   logic [PHY_DATA_W-1:0] ctrl_n, stat_n, adv_n, msk_n, src_n;
   logic                  wr_ok, rd_ok, src_rd;
   logic [PHY_DATA_W-1:0] rd_tbl [REG_COUNT];

   assign wr_ok    = acc && hit && !op.rd;
   assign rd_ok    = acc && hit && op.rd;
   assign src_rd   = rd_ok && (int'(op.regn) == REG_EVT_SRC);
   assign soft_rst = wr_ok && (int'(op.regn) == REG_CTRL) && op.data[CTRL_RESET_BIT];

   // read table: one entry per register number, chosen at elaboration
   for (genvar g = 0; g < REG_COUNT; g++) begin : g_rd
      if (g == REG_CTRL) begin : g_ctrl
         assign rd_tbl[g] = ctrl_q;
      end else if (g == REG_STAT) begin : g_stat
         assign rd_tbl[g] = stat_q;
      end else if (g == REG_ID_HI) begin : g_idh
         assign rd_tbl[g] = ID_HI_VAL;
      end else if (g == REG_ID_LO) begin : g_idl
         assign rd_tbl[g] = ID_LO_VAL;
      end else if (g == REG_ADV) begin : g_adv
         assign rd_tbl[g] = adv_q;
      end else if (g == REG_PARTNER) begin : g_lpa
         assign rd_tbl[g] = PARTNER_VAL;
      end else if (g == REG_ANEXP) begin : g_exp
         assign rd_tbl[g] = ANEXP_VAL;
      end else if (g == REG_EVT_SRC) begin : g_src
         assign rd_tbl[g] = src_q;
      end else if (g == REG_EVT_MSK) begin : g_msk
         assign rd_tbl[g] = msk_q;
      end else begin : g_zero
         assign rd_tbl[g] = '0;
      end
   end

   assign rd_data = hit ? rd_tbl[op.regn] : MISS_VAL;

   always_comb begin
      ctrl_n = ctrl_q;
      stat_n = stat_q;
      adv_n  = adv_q;
      msk_n  = msk_q;
      src_n  = src_q;
      if (wr_ok) begin
         case (int'(op.regn))
            REG_CTRL: begin
               if (!op.data[CTRL_RESET_BIT]) begin
                  ctrl_n = op.data & CTRL_KEEP;
                  if (op.data[CTRL_AN_BIT]) stat_n = stat_n | STAT_ANDONE;
               end
            end
            REG_ADV:     adv_n = (op.data & ADV_KEEP) | ADV_FORCE;
            REG_EVT_MSK: msk_n = op.data & MSK_KEEP;
            default: ;
         endcase
      end
      if (src_rd) src_n = '0;
      if (link_evt) begin
         if (link_up) begin
            stat_n = stat_n | STAT_LINK;
            src_n  = src_n | SRC_UP;
         end else begin
            stat_n = stat_n & ~STAT_LINK;
            src_n  = src_n | SRC_DOWN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         stat_q <= STAT_RST;
         adv_q  <= ADV_RST;
         msk_q  <= '0;
         src_q  <= '0;
      end else if (soft_rst) begin
         ctrl_q <= CTRL_RST;
         stat_q <= STAT_RST;
         adv_q  <= ADV_RST;
         msk_q  <= '0;
         src_q  <= '0;
      end else begin
         ctrl_q <= ctrl_n;
         stat_q <= stat_n;
         adv_q  <= adv_n;
         msk_q  <= msk_n;
         src_q  <= src_n;
      end
   end

   assert_ctrl_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_KEEP) == '0);

   assert_adv_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv_q[7] && ((adv_q & ~(ADV_KEEP | ADV_FORCE)) == '0));

   assert_src_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd && !link_evt && !soft_rst |=> src_q == '0);

   assert_link_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt && link_up && !soft_rst |=> (stat_q & STAT_LINK) == STAT_LINK);

   assert_link_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt && !link_up && !soft_rst |=> (stat_q & STAT_LINK) == '0 && src_q[4]);

   assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !link_evt && !src_rd && !soft_rst |=> $stable(src_q));

   assert_miss_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !hit && !link_evt |=> $stable(ctrl_q) && $stable(adv_q) && $stable(msk_q)
                                   && $stable(stat_q));

endmodule

// File: rtl/mii_phy_regmodel.sv
module mii_phy_regmodel
   import phy_mgmt_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int OP_BIT   = 29,
   parameter int ADDR_LSB = 18,
   parameter int PHY_ADDR = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_we,
   input  logic [FRAME_W-1:0] frame_wdata,
   input  logic               done_clr,
   input  logic               link_up,
   output logic [FRAME_W-1:0] frame_rdata,
   output logic               mgmt_done
);

   localparam int ADDR_MSB = ADDR_LSB + MGMT_ADDR_W - 1;

   if (FRAME_W < PHY_DATA_W + MGMT_ADDR_W + 1) begin : g_bad_width
      $error("frame word too narrow for data, address and operation bit");
   end
   if (ADDR_LSB < PHY_DATA_W || ADDR_MSB >= FRAME_W) begin : g_bad_addr
      $error("address field must sit above the data field inside the frame");
   end
   if (OP_BIT < PHY_DATA_W || OP_BIT >= FRAME_W ||
       (OP_BIT >= ADDR_LSB && OP_BIT <= ADDR_MSB)) begin : g_bad_op
      $error("operation bit overlaps another field or lies outside the frame");
   end
   if (PHY_ADDR < 0 || PHY_ADDR >= (1 << PHY_FIELD_W)) begin : g_bad_phy
      $error("PHY_ADDR does not fit the PHY number field");
   end

   mgmt_op_t              op;
   logic                  hit;
   logic                  link_evt;
   logic                  soft_rst;
   logic [PHY_DATA_W-1:0] rd_data;
   logic [FRAME_W-1:0]    frame_q;
   logic                  done_q;

   phy_frame_decode #(
      .FRAME_W (FRAME_W),
      .OP_BIT  (OP_BIT),
      .ADDR_LSB(ADDR_LSB),
      .PHY_ADDR(PHY_ADDR)
   ) u_dec (
      .frame(frame_wdata),
      .op   (op),
      .hit  (hit)
   );

   phy_link_watch u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .rearm  (soft_rst),
      .link_in(link_up),
      .evt    (link_evt)
   );

   phy_reg_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (frame_we),
      .hit     (hit),
      .op      (op),
      .link_evt(link_evt),
      .link_up (link_up),
      .rd_data (rd_data),
      .soft_rst(soft_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (frame_we) begin
            frame_q <= op.rd ? {frame_wdata[FRAME_W-1:PHY_DATA_W], rd_data} : frame_wdata;
         end
         done_q <= frame_we | (done_q & ~done_clr);
      end
   end

   assign frame_rdata = frame_q;
   assign mgmt_done   = done_q;

   assert_done_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> mgmt_done);

   assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr && !frame_we |=> !mgmt_done);

   assert_miss_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we && op.rd && !hit |=> frame_rdata[PHY_DATA_W-1:0] == MISS_VAL);

   assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> frame_rdata[FRAME_W-1:PHY_DATA_W] == $past(frame_wdata[FRAME_W-1:PHY_DATA_W]));

   assert_write_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we && !op.rd |=> frame_rdata == $past(frame_wdata));

endmodule

// File: tb/tb_mii_phy_regmodel.sv
`timescale 1ns/100ps
module tb_mii_phy_regmodel;

   localparam int PHY = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_we;
   logic [31:0] frame_wdata;
   logic        done_clr;
   logic        link_up;
   logic [31:0] frame_rdata;
   logic        mgmt_done;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   time         t_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   mii_phy_regmodel #(.PHY_ADDR(PHY)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_we   (frame_we),
      .frame_wdata(frame_wdata),
      .done_clr   (done_clr),
      .link_up    (link_up),
      .frame_rdata(frame_rdata),
      .mgmt_done  (mgmt_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bits 31:30 and 17:16 carry a pattern that must survive every access (R2)
   function automatic logic [31:0] mk(input bit rd, input int phy, input int rg,
                                      input logic [15:0] d);
      mk = 32'h4002_0000 | (32'(rd) << 29) | (32'(phy) << 23) | (32'(rg) << 18) | 32'(d);
   endfunction

   // driver: issues one access and pushes the expected frame register value
   task automatic access(input bit rd, input int phy, input int rg,
                         input logic [15:0] d, input logic [15:0] rv, input string tag);
      logic [31:0] w;
      w = mk(rd, phy, rg, d);
      @(negedge clk);
      frame_we    = 1'b1;
      frame_wdata = w;
      exp_q.push_back(rd ? {w[31:16], rv} : w);
      t_q.push_back($time);
      tag_q.push_back(tag);
      @(posedge clk);
      #1 frame_we = 1'b0;
   endtask

   task automatic rd_reg(input int phy, input int rg, input logic [15:0] rv, input string tag);
      access(1'b1, phy, rg, 16'h5A5A, rv, tag);
   endtask

   task automatic wr_reg(input int phy, input int rg, input logic [15:0] d, input string tag);
      access(1'b0, phy, rg, d, 16'h0, tag);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: compares each pushed item one falling edge after its capture edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() != 0 && t_q[0] < $time) begin
            chk(tag_q[0], frame_rdata, exp_q[0]);
            void'(exp_q.pop_front());
            void'(t_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n       = 1'b0;
      frame_we    = 1'b0;
      frame_wdata = '0;
      done_clr    = 1'b0;
      link_up     = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 frame at reset", frame_rdata, 32'h0);
      chk("R1 done at reset", 32'(mgmt_done), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset values with link applied once
      rd_reg(PHY, 1, 16'h782D, "R1 status");
      rd_reg(PHY, 0, 16'h3000, "R1 control");
      rd_reg(PHY, 4, 16'h01E1, "R1 advert");
      rd_reg(PHY, 30, 16'h0000, "R1 mask");
      // R8 source read returns then clears
      rd_reg(PHY, 29, 16'h00C0, "R8 source first");
      rd_reg(PHY, 29, 16'h0000, "R8 source cleared");
      // R4 fixed identification values
      rd_reg(PHY, 2, 16'h0007, "R4 reg2");
      rd_reg(PHY, 3, 16'hC0D1, "R4 reg3");
      rd_reg(PHY, 5, 16'h0F71, "R4 reg5");
      rd_reg(PHY, 6, 16'h0001, "R4 reg6");
      // R3 foreign PHY number
      rd_reg(PHY + 1, 1, 16'hFFFF, "R3 foreign read");
      wr_reg(PHY + 1, 4, 16'h0000, "R3 foreign write echo");
      rd_reg(PHY, 4, 16'h01E1, "R3 advert untouched");
      // R7 write masks
      wr_reg(PHY, 4, 16'hFFFF, "R7 advert write echo");
      rd_reg(PHY, 4, 16'h2DFF, "R7 advert all ones");
      wr_reg(PHY, 4, 16'h0000, "R7 advert write echo");
      rd_reg(PHY, 4, 16'h0080, "R7 advert zero");
      wr_reg(PHY, 30, 16'h1234, "R7 mask write echo");
      rd_reg(PHY, 30, 16'h0034, "R7 mask");
      drain();

      // R9 link down edge
      link_up = 1'b0;
      repeat (2) @(negedge clk);
      rd_reg(PHY, 1, 16'h7809, "R9 status link down");
      rd_reg(PHY, 29, 16'h0010, "R9 source link down");
      rd_reg(PHY, 29, 16'h0000, "R9 no event while steady");
      // R5 control masking and instant autonegotiation
      wr_reg(PHY, 0, 16'h1000, "R5 control write echo");
      rd_reg(PHY, 1, 16'h7829, "R5 autoneg done bit");
      rd_reg(PHY, 0, 16'h1000, "R5 control an");
      wr_reg(PHY, 0, 16'h6A5F, "R5 control write echo");
      rd_reg(PHY, 0, 16'h6800, "R5 control masked");
      // R10 unimplemented and read-only registers
      wr_reg(PHY, 17, 16'hFFFF, "R10 write echo");
      rd_reg(PHY, 17, 16'h0000, "R10 reg17");
      rd_reg(PHY, 31, 16'h0000, "R10 reg31");
      rd_reg(PHY, 9, 16'h0000, "R10 undefined reg9");
      wr_reg(PHY, 1, 16'h0000, "R10 write echo");
      rd_reg(PHY, 1, 16'h7829, "R10 status read-only");
      drain();

      // R9 link up edge
      link_up = 1'b1;
      repeat (2) @(negedge clk);
      rd_reg(PHY, 1, 16'h782D, "R9 status link up");
      rd_reg(PHY, 29, 16'h00C0, "R9 source link up");
      rd_reg(PHY, 30, 16'h0034, "R9 mask kept");
      // R6 soft reset then link reapplied
      wr_reg(PHY, 0, 16'h8000, "R6 reset write echo");
      drain();
      repeat (2) @(negedge clk);
      rd_reg(PHY, 0, 16'h3000, "R6 control");
      rd_reg(PHY, 4, 16'h01E1, "R6 advert");
      rd_reg(PHY, 30, 16'h0000, "R6 mask");
      rd_reg(PHY, 1, 16'h782D, "R6 status");
      rd_reg(PHY, 29, 16'h00C0, "R6 source reapplied");
      drain();

      // R11 done flag
      chk("R11 done after access", 32'(mgmt_done), 32'h1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R11 done cleared", 32'(mgmt_done), 32'h0);
      @(negedge clk);
      done_clr    = 1'b1;
      frame_we    = 1'b1;
      frame_wdata = mk(1'b1, PHY + 2, 0, 16'h0);
      @(negedge clk);
      done_clr = 1'b0;
      frame_we = 1'b0;
      chk("R11 access wins over clear", 32'(mgmt_done), 32'h1);
      chk("R2 foreign read frame", frame_rdata, {mk(1'b1, PHY + 2, 0, 16'h0) & 32'hFFFF_0000} | 32'hFFFF);

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule